// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block keeps a small set of list entries that describe the virtual interrupts offered to a guest CPU interface. Each entry holds a virtual interrupt ID, a two-bit state, a hardware-link flag and, for linked entries, the ID of the physical interrupt it stands for. Software fills entries through a single-cycle write port and can read any entry back through an index-addressed read port.

The guest side issues two operations. An acknowledge picks the lowest-indexed entry whose pending bit is set, reports its virtual ID one cycle later and moves it to active. If no entry is pending, the reported ID is the spurious value 1023. A deactivate names a virtual ID. It clears the active bit of the lowest-indexed active entry that carries that ID. If that entry is linked, the block pulses a deactivate request with the physical ID toward the physical distributor. A deactivate that finds no match changes nothing and raises an error pulse.

Software writes are checked before they land. A linked entry may never be both pending and active. Linking is refused for virtual IDs at or above the message-based threshold (8192), because those interrupts have no active state. A refused write leaves the entry untouched and raises a one-cycle reject flag.

Top module: `lr_bank`

## Requirements
- R1: While reset is high, and on the first cycle after it, every entry reads back as inactive (state 2'b00), and ack_valid, dist_valid, deact_err and wr_reject are low.
- R2: A write that passes the checks stores virtual ID, state, link flag and physical ID into entry wr_idx. The stored values are visible on the read port from the next cycle. State encoding: bit 0 = pending, bit 1 = active (00 inactive, 01 pending, 10 active, 11 pending-and-active).
- R3: An acknowledge selects the lowest-indexed entry with its pending bit set. The cycle after the request, ack_valid is high and ack_vid holds that entry's virtual ID. The entry's state becomes active (01 -> 10 and 11 -> 10).
- R4: An acknowledge with no pending entry gives ack_valid with ack_vid = 1023 and leaves every entry unchanged.
- R5: A deactivate clears the active bit of the lowest-indexed entry whose active bit is set and whose virtual ID equals deact_vid (10 -> 00, 11 -> 01). Other entries with the same ID keep their state.
- R6: When the deactivated entry is linked, dist_valid is high for exactly the following cycle with dist_pid equal to its physical ID. An unlinked entry produces no pulse.
- R7: A write with the link flag set and state 11 is rejected: the entry keeps its old contents and wr_reject is high the following cycle.
- R8: A write with the link flag set and a virtual ID of 8192 or more is rejected in the same way. A linked write with ID 8191 is accepted.
- R9: A deactivate whose ID matches no active entry changes no entry, produces no dist_valid, and raises deact_err for the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | 2 | Entry index being written |
| wr_vid | input | 14 | Virtual interrupt ID to store |
| wr_state | input | 2 | State to store (bit0 pending, bit1 active) |
| wr_link | input | 1 | Hardware-link flag to store |
| wr_pid | input | 10 | Physical interrupt ID to store |
| wr_reject | output | 1 | Previous cycle's write was refused |
| rd_idx | input | 2 | Entry index for read-back |
| rd_vid | output | 14 | Virtual ID of entry rd_idx |
| rd_state | output | 2 | State of entry rd_idx |
| rd_link | output | 1 | Link flag of entry rd_idx |
| rd_pid | output | 10 | Physical ID of entry rd_idx |
| ack_req | input | 1 | Guest acknowledge request |
| ack_valid | output | 1 | Acknowledge answer is valid |
| ack_vid | output | 14 | Acknowledged virtual ID, or 1023 |
| deact_req | input | 1 | Guest deactivate request |
| deact_vid | input | 14 | Virtual ID to deactivate |
| deact_err | output | 1 | Previous deactivate matched nothing |
| dist_valid | output | 1 | Physical deactivate request to the distributor |
| dist_pid | output | 10 | Physical ID carried by the request |

## Verification
The bench goes after tie-breaking: several entries pending at once, and two active entries sharing one virtual ID. A design with a wrong priority encoder would answer with a higher index or clear the wrong entry. It drives the pending-and-active paths for both operations, where a design that overwrites the state instead of touching single bits would drop the retained pending or active bit. The refusal rules are probed at the 8191/8192 edge and with a linked pending-and-active write; a lax check would let an illegal linked entry land, and read-back would show it. Deactivates of unlinked entries, and of IDs that are no longer active, test that no stray distributor pulse leaks out and that the error pulse appears only on a miss.

// File: rtl/lr_pkg.sv
package lr_pkg;

   typedef enum logic [1:0] {
      LR_IDLE = 2'b00,
      LR_PEND = 2'b01,
      LR_ACT  = 2'b10,
      LR_PACT = 2'b11
   } lr_state_e;

   localparam int unsigned LR_SPURIOUS_ID = 1023;
   localparam int unsigned LR_MSG_BASE    = 8192;

endpackage

// File: rtl/lr_wr_check.sv
module lr_wr_check #(
   parameter int unsigned VID_W    = 14,
   parameter int unsigned MSG_BASE = 8192
) (
   input  logic [VID_W-1:0] vid,
   input  logic [1:0]       state,
   input  logic             link,
   output logic             ok
);
   logic both_bits;
   logic msg_range;

   assign both_bits = link && (state == lr_pkg::LR_PACT);

   generate
      if (MSG_BASE >= (64'd1 << VID_W)) begin : g_no_msg
         assign msg_range = 1'b0;
      end else begin : g_msg
         assign msg_range = link && (32'(vid) >= MSG_BASE);
      end
   endgenerate

   assign ok = !both_bits && !msg_range;

endmodule

// File: rtl/lr_first.sv
module lr_first #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   always_comb begin
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/lr_entry.sv
module lr_entry #(
   parameter int unsigned VID_W = 14,
   parameter int unsigned PID_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [VID_W-1:0] load_vid,
   input  logic [1:0]       load_state,
   input  logic             load_link,
   input  logic [PID_W-1:0] load_pid,
   input  logic             take,
   input  logic             retire,
   output logic [VID_W-1:0] vid,
   output logic [1:0]       state,
   output logic             link,
   output logic [PID_W-1:0] pid
);
   logic pend_n;
   logic act_n;

   // take clears pending and sets active; retire clears active
   assign pend_n = state[0] && !take;
   assign act_n  = (state[1] && !retire) || take;

   always_ff @(posedge clk) begin
      if (rst) begin
         vid   <= '0;
         state <= lr_pkg::LR_IDLE;
         link  <= 1'b0;
         pid   <= '0;
      end else if (load) begin
         vid   <= load_vid;
         state <= load_state;
         link  <= load_link;
         pid   <= load_pid;
      end else begin
         state <= {act_n, pend_n};
      end
   end

endmodule

// File: rtl/lr_bank.sv
module lr_bank #(
   parameter int unsigned N_LR     = 4,
   parameter int unsigned VID_W    = 14,
   parameter int unsigned PID_W    = 10,
   parameter int unsigned SPUR_ID  = lr_pkg::LR_SPURIOUS_ID,
   parameter int unsigned MSG_BASE = lr_pkg::LR_MSG_BASE,
   localparam int unsigned IDX_W   = $clog2(N_LR)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VID_W-1:0] wr_vid,
   input  logic [1:0]       wr_state,
   input  logic             wr_link,
   input  logic [PID_W-1:0] wr_pid,
   output logic             wr_reject,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [VID_W-1:0] rd_vid,
   output logic [1:0]       rd_state,
   output logic             rd_link,
   output logic [PID_W-1:0] rd_pid,
   input  logic             ack_req,
   output logic             ack_valid,
   output logic [VID_W-1:0] ack_vid,
   input  logic             deact_req,
   input  logic [VID_W-1:0] deact_vid,
   output logic             deact_err,
   output logic             dist_valid,
   output logic [PID_W-1:0] dist_pid
);
   generate
      if (N_LR < 2 || N_LR > 64) begin : g_bad_depth
         $error("lr_bank: N_LR must lie in 2..64");
      end
      if ((64'd1 << IDX_W) != N_LR) begin : g_bad_pow2
         $error("lr_bank: N_LR must be a power of two");
      end
      if (SPUR_ID >= (64'd1 << VID_W)) begin : g_bad_spur
         $error("lr_bank: spurious ID does not fit VID_W");
      end
      if (PID_W < 1 || VID_W < 1) begin : g_bad_width
         $error("lr_bank: ID widths must be positive");
      end
   endgenerate

   logic [VID_W-1:0]           vid_q  [N_LR];
   logic [PID_W-1:0]           pid_q  [N_LR];
   logic [N_LR-1:0][1:0]       st_pk;
   logic [N_LR-1:0]            lnk_pk;

   logic                       wr_ok;
   logic [N_LR-1:0]            pend_vec, ack_gnt, ack_hit;
   logic [N_LR-1:0]            match_vec, dea_gnt, dea_hit;
   logic                       ack_any, dea_any;
   logic [VID_W-1:0]           ack_sel_vid;
   logic [PID_W-1:0]           dea_sel_pid;
   logic                       dea_sel_link;

   lr_wr_check #(.VID_W(VID_W), .MSG_BASE(MSG_BASE)) u_check (
      .vid   (wr_vid),
      .state (wr_state),
      .link  (wr_link),
      .ok    (wr_ok)
   );

   for (genvar i = 0; i < N_LR; i++) begin : g_lr
      logic [1:0] st_i;
      logic       lnk_i;

      assign pend_vec[i]  = st_pk[i][0];
      assign match_vec[i] = st_pk[i][1] && (vid_q[i] == deact_vid);
      assign ack_hit[i]   = ack_req && ack_gnt[i];
      assign dea_hit[i]   = deact_req && dea_gnt[i];

      lr_entry #(.VID_W(VID_W), .PID_W(PID_W)) u_entry (
         .clk        (clk),
         .rst        (rst),
         .load       (wr_en && wr_ok && (wr_idx == IDX_W'(i))),
         .load_vid   (wr_vid),
         .load_state (wr_state),
         .load_link  (wr_link),
         .load_pid   (wr_pid),
         .take       (ack_hit[i]),
         .retire     (dea_hit[i]),
         .vid        (vid_q[i]),
         .state      (st_i),
         .link       (lnk_i),
         .pid        (pid_q[i])
      );

      assign st_pk[i]  = st_i;
      assign lnk_pk[i] = lnk_i;
   end

   lr_first #(.N(N_LR)) u_ack_pick (
      .req   (pend_vec),
      .grant (ack_gnt),
      .any   (ack_any)
   );

   lr_first #(.N(N_LR)) u_dea_pick (
      .req   (match_vec),
      .grant (dea_gnt),
      .any   (dea_any)
   );

   // one-hot grants make an OR-mux sufficient
   always_comb begin
      ack_sel_vid  = '0;
      dea_sel_pid  = '0;
      dea_sel_link = 1'b0;
      for (int i = 0; i < N_LR; i++) begin
         ack_sel_vid  = ack_sel_vid  | (ack_gnt[i] ? vid_q[i] : '0);
         dea_sel_pid  = dea_sel_pid  | (dea_gnt[i] ? pid_q[i] : '0);
         dea_sel_link = dea_sel_link | (dea_gnt[i] && lnk_pk[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_valid  <= 1'b0;
         ack_vid    <= '0;
         dist_valid <= 1'b0;
         dist_pid   <= '0;
         deact_err  <= 1'b0;
         wr_reject  <= 1'b0;
      end else begin
         ack_valid  <= ack_req;
         ack_vid    <= ack_any ? ack_sel_vid : VID_W'(SPUR_ID);
         dist_valid <= deact_req && dea_any && dea_sel_link;
         dist_pid   <= dea_sel_pid;
         deact_err  <= deact_req && !dea_any;
         wr_reject  <= wr_en && !wr_ok;
      end
   end

   assign rd_vid   = vid_q[rd_idx];
   assign rd_state = st_pk[rd_idx];
   assign rd_link  = lnk_pk[rd_idx];
   assign rd_pid   = pid_q[rd_idx];

endmodule

// File: rtl/lr_bank_chk.sv
module lr_bank_chk #(
   parameter int unsigned N_LR     = 4,
   parameter int unsigned VID_W    = 14,
   parameter int unsigned MSG_BASE = 8192
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 wr_en,
   input logic                 wr_link,
   input logic [VID_W-1:0]     wr_vid,
   input logic [1:0]           wr_state,
   input logic                 wr_reject,
   input logic                 ack_req,
   input logic                 ack_valid,
   input logic                 deact_req,
   input logic                 deact_err,
   input logic                 dist_valid,
   input logic [N_LR-1:0][1:0] st_pk,
   input logic [N_LR-1:0]      lnk_pk
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (st_pk == '0 && !ack_valid && !dist_valid && !deact_err && !wr_reject));

   p_ack_answer_r3: assert property (@(posedge clk) disable iff (rst)
      ack_req |=> ack_valid);

   p_dist_cause_r6: assert property (@(posedge clk) disable iff (rst)
      dist_valid |-> $past(deact_req));

   p_pa_reject_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_link && wr_state == 2'b11) |=> wr_reject);

   p_msg_reject_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_link && 32'(wr_vid) >= MSG_BASE) |=> wr_reject);

   p_err_alone_r9: assert property (@(posedge clk) disable iff (rst)
      deact_err |-> (!dist_valid && $past(deact_req)));

   for (genvar i = 0; i < N_LR; i++) begin : g_ent
      p_link_no_pa_r7: assert property (@(posedge clk) disable iff (rst)
         !(lnk_pk[i] && st_pk[i] == 2'b11));
   end

endmodule

bind lr_bank lr_bank_chk #(.N_LR(N_LR), .VID_W(VID_W), .MSG_BASE(MSG_BASE)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_en      (wr_en),
   .wr_link    (wr_link),
   .wr_vid     (wr_vid),
   .wr_state   (wr_state),
   .wr_reject  (wr_reject),
   .ack_req    (ack_req),
   .ack_valid  (ack_valid),
   .deact_req  (deact_req),
   .deact_err  (deact_err),
   .dist_valid (dist_valid),
   .st_pk      (st_pk),
   .lnk_pk     (lnk_pk)
);

// File: tb/lr_bank_bench.sv
module lr_bank_bench;
   localparam int VID_W = 14;
   localparam int PID_W = 10;
   localparam int EV_ACK = 0, EV_DIST = 1, EV_ERR = 2, EV_REJ = 3;

   typedef struct {
      int    kind;
      int    val;
      string tag;
   } ev_t;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_idx = '0;
   logic [VID_W-1:0] wr_vid = '0;
   logic [1:0]       wr_state = '0;
   logic             wr_link = 1'b0;
   logic [PID_W-1:0] wr_pid = '0;
   logic             wr_reject;
   logic [1:0]       rd_idx = '0;
   logic [VID_W-1:0] rd_vid;
   logic [1:0]       rd_state;
   logic             rd_link;
   logic [PID_W-1:0] rd_pid;
   logic             ack_req = 1'b0;
   logic             ack_valid;
   logic [VID_W-1:0] ack_vid;
   logic             deact_req = 1'b0;
   logic [VID_W-1:0] deact_vid = '0;
   logic             deact_err;
   logic             dist_valid;
   logic [PID_W-1:0] dist_pid;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 0;
   ev_t exp_q[$];

   always #2 clk = ~clk;

   lr_bank u_lr_bank (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vid(wr_vid), .wr_state(wr_state),
      .wr_link(wr_link), .wr_pid(wr_pid), .wr_reject(wr_reject),
      .rd_idx(rd_idx), .rd_vid(rd_vid), .rd_state(rd_state),
      .rd_link(rd_link), .rd_pid(rd_pid),
      .ack_req(ack_req), .ack_valid(ack_valid), .ack_vid(ack_vid),
      .deact_req(deact_req), .deact_vid(deact_vid), .deact_err(deact_err),
      .dist_valid(dist_valid), .dist_pid(dist_pid)
   );

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic string kind_req(int k);
      case (k)
         EV_ACK:  return "R3";
         EV_DIST: return "R6";
         EV_ERR:  return "R9";
         default: return "R7/R8";
      endcase
   endfunction

   task automatic take(int kind, int val);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(0, kind_req(kind), "unexpected output event kind/value", val, -1);
      end else begin
         e = exp_q.pop_front();
         chk(e.kind == kind, e.tag, "event kind", kind, e.kind);
         chk(e.val == val, e.tag, "event value", val, e.val);
      end
   endtask

   // monitor: outputs are registered, stable at the falling edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (ack_valid)  take(EV_ACK, int'(ack_vid));
         if (dist_valid) take(EV_DIST, int'(dist_pid));
         if (deact_err)  take(EV_ERR, 0);
         if (wr_reject)  take(EV_REJ, 0);
      end
   end

   task automatic push(int kind, int val, string tag);
      ev_t e;
      e.kind = kind; e.val = val; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic do_write(int idx, int vid, int st, bit lnk, int pid, bit rej, string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 2'(idx); wr_vid = VID_W'(vid);
      wr_state = 2'(st); wr_link = lnk; wr_pid = PID_W'(pid);
      if (rej) push(EV_REJ, 0, tag);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_ack(int exp_vid, string tag);
      @(negedge clk);
      ack_req = 1'b1;
      push(EV_ACK, exp_vid, tag);
      @(negedge clk);
      ack_req = 1'b0;
   endtask

   // outcome: 0 quiet, 1 distributor pulse with pid, 2 error pulse
   task automatic do_deact(int vid, int outcome, int pid, string tag);
      @(negedge clk);
      deact_req = 1'b1; deact_vid = VID_W'(vid);
      if (outcome == 1) push(EV_DIST, pid, tag);
      if (outcome == 2) push(EV_ERR, 0, tag);
      @(negedge clk);
      deact_req = 1'b0;
   endtask

   task automatic see(int idx, int st, int vid, bit lnk, int pid, string tag);
      rd_idx = 2'(idx);
      #1;
      chk(rd_state == 2'(st), tag, $sformatf("entry %0d state", idx), int'(rd_state), st);
      chk(rd_vid == VID_W'(vid), tag, $sformatf("entry %0d vid", idx), int'(rd_vid), vid);
      chk(rd_link == lnk, tag, $sformatf("entry %0d link", idx), int'(rd_link), int'(lnk));
      if (lnk) chk(rd_pid == PID_W'(pid), tag, $sformatf("entry %0d pid", idx), int'(rd_pid), pid);
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(0, "watchdog", "run did not finish", 0, 1);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state during reset
      for (int i = 0; i < 4; i++) see(i, 0, 0, 0, 0, "R1");
      chk(!ack_valid && !dist_valid && !deact_err && !wr_reject, "R1", "outputs low", 0, 0);
      rst = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 4; i++) see(i, 0, 0, 0, 0, "R1");

      // R2: legal writes, including unlinked pending-and-active
      do_write(0, 35, 1, 0, 0, 0, "R2");
      do_write(1, 100, 1, 1, 7, 0, "R2");
      do_write(2, 200, 3, 0, 0, 0, "R2");
      do_write(3, 300, 0, 0, 0, 0, "R2");
      see(0, 1, 35, 0, 0, "R2");
      see(1, 1, 100, 1, 7, "R2");
      see(2, 3, 200, 0, 0, "R2");
      see(3, 0, 300, 0, 0, "R2");

      // R7: linked pending-and-active refused
      do_write(3, 300, 3, 1, 4, 1, "R7");
      see(3, 0, 300, 0, 0, "R7");
      // R8: link refused at 9000 and at the threshold 8192, accepted at 8191
      do_write(3, 9000, 1, 1, 5, 1, "R8");
      see(3, 0, 300, 0, 0, "R8");
      do_write(3, 8192, 1, 1, 5, 1, "R8");
      see(3, 0, 300, 0, 0, "R8");
      do_write(3, 8191, 1, 1, 12, 0, "R8");
      see(3, 1, 8191, 1, 12, "R8");

      // R3: lowest index first, pending -> active, pending-and-active -> active
      do_ack(35, "R3");
      see(0, 2, 35, 0, 0, "R3");
      see(1, 1, 100, 1, 7, "R3");
      do_ack(100, "R3");
      do_ack(200, "R3");
      see(2, 2, 200, 0, 0, "R3");
      do_ack(8191, "R3");
      see(3, 2, 8191, 1, 12, "R3");

      // R4: nothing pending
      do_ack(1023, "R4");
      for (int i = 0; i < 4; i++) begin
         rd_idx = 2'(i);
         #1;
         chk(rd_state == 2'b10, "R4", $sformatf("entry %0d unchanged", i), int'(rd_state), 2);
      end

      // R6/R5: linked deactivate pulses the distributor
      do_deact(100, 1, 7, "R6");
      see(1, 0, 100, 1, 7, "R5");
      // R6: unlinked deactivate is quiet
      do_deact(35, 0, 0, "R6");
      see(0, 0, 35, 0, 0, "R5");
      // R9: no active match
      do_deact(35, 2, 0, "R9");
      see(0, 0, 35, 0, 0, "R9");
      see(2, 2, 200, 0, 0, "R9");
      do_deact(8191, 1, 12, "R6");
      see(3, 0, 8191, 1, 12, "R5");

      // R5: pending-and-active keeps the pending bit
      do_write(0, 55, 3, 0, 0, 0, "R2");
      do_deact(55, 0, 0, "R5");
      see(0, 1, 55, 0, 0, "R5");
      do_ack(55, "R3");
      see(0, 2, 55, 0, 0, "R3");

      // R5: two active entries with one ID, lowest index retired first
      do_write(1, 200, 2, 1, 9, 0, "R2");
      do_deact(200, 1, 9, "R5");
      see(1, 0, 200, 1, 9, "R5");
      see(2, 2, 200, 0, 0, "R5");
      do_deact(200, 0, 0, "R5");
      see(2, 0, 200, 0, 0, "R5");

      repeat (3) @(negedge clk);
      while (exp_q.size() > 0) begin
         ev_t e;
         e = exp_q.pop_front();
         chk(0, e.tag, "expected event missing", -1, e.val);
      end
      finish_run();
   end

endmodule